// File: doc/BRIEF.md
# Set-Associative Data Translation Buffer

This block turns a data virtual address into a physical address through a small set-associative translation buffer. Each set holds one entry per way. An entry has two parts. The match part holds a virtual tag, a valid bit and a usage counter. The translate part holds a physical page number, a cache-inhibit bit and four access enables, split by privilege (user or supervisor) and by access type (read or write).

A lookup is presented for one cycle with `reqValid` high. One clock later the block returns:
- the physical address,
- the cache-inhibit flag,
- a hit flag,
- and, for ordinary lookups, a one-cycle page-fault or miss pulse.

A probe lookup (`reqProbe`) performs the same search but leaves no trace. It raises no exception and does not touch the usage counters. It reports a miss or a permission failure as an all-zero address. It changes the cache-inhibit flag only when `reqThroughCache` is set and the probe succeeds.

Software fills the entries and inspects them through an entry access port. That port is a single-cycle write strobe plus a combinational read-back of the addressed word. Refill on a miss is left to the exception handler.

Top module: `data_tlb`

## Requirements
- R1: With `mmuEnable` low (or parameter `HAS_MMU` = 0):
  - `physAddr` equals the request address;
  - `cacheInhibit` equals address bit 31, i.e. the address is at or above 0x80000000;
  - `hit`, `pageFault` and `tlbMiss` stay low.
  - For a probe, `cacheInhibit` is loaded only when `reqThroughCache` is set.
- R2: The set index is address bits [16:13]. The compared tag is address bits [31:17] (8 KiB pages, 16 sets by default). A way hits only when it is valid and its tag equals the lookup tag.
- R3: When several ways of a set hit, the highest-numbered way supplies the translation.
- R4: The access needs one enable bit of the hit entry, chosen as follows:

  | Mode | Access | Enable used |
  |---|---|---|
  | supervisor (`superMode`=1) | write | supervisor-write |
  | supervisor (`superMode`=1) | read | supervisor-read |
  | user | write | user-write |
  | user | read | user-read |

  If that bit is clear, an ordinary lookup pulses `pageFault` for one cycle, in the cycle after the request. The translated address is still returned.
- R5: On a hit, `physAddr` is {stored page number, address bits [12:0]}, and an ordinary lookup loads `cacheInhibit` from the entry's inhibit bit.
- R6: After an ordinary hit, every other way of that set with a nonzero usage counter has decremented it by one. The hit way's counter reads USE_STATES-1 (3 by default).
- R7: On an ordinary miss:
  - `tlbMiss` pulses for one cycle;
  - `physAddr` is 0 and `hit` is 0;
  - `cacheInhibit` holds its value;
  - no entry changes.
- R8: A probe never pulses `pageFault` or `tlbMiss` and never changes a usage counter.
  - On a miss or a permission failure it returns address 0.
  - It loads `cacheInhibit` only when it succeeds and `reqThroughCache` is set.
- R9: After reset:
  - every valid bit and usage counter reads 0;
  - `rspValid`, `hit`, `pageFault`, `tlbMiss`, `cacheInhibit` and `physAddr` are 0.
- R10: When an entry write and a lookup fall in the same cycle, the lookup sees the old contents. The write then lands over any counter update of the same entry.
- R11: The entry access port is addressed by `entSet`, `entWay` and `entSel` (0 = match word, 1 = translate word). Writes happen on `entWr`, and `entRdData` returns the addressed word combinationally.
  - Match word bits:
    | Bits | Field |
    |---|---|
    | 0 | valid |
    | [3:2] | usage counter |
    | [31:17] | tag |
  - Translate word bits:
    | Bits | Field |
    |---|---|
    | 0 | cache-inhibit |
    | 1 | user-read |
    | 2 | user-write |
    | 3 | supervisor-read |
    | 4 | supervisor-write |
    | [31:13] | page number |
  - Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request this cycle |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqProbe | input | 1 | Side-effect-free lookup |
| reqThroughCache | input | 1 | Probe may update the cache-inhibit flag |
| superMode | input | 1 | Supervisor privilege |
| mmuEnable | input | 1 | Translation enabled |
| entWr | input | 1 | Write strobe of the entry port |
| entSel | input | 1 | 0 = match word, 1 = translate word |
| entWay | input | 1 | Way addressed by the entry port |
| entSet | input | 4 | Set addressed by the entry port |
| entWrData | input | 32 | Entry write data |
| entRdData | output | 32 | Read-back of the addressed entry word |
| rspValid | output | 1 | Result registers were loaded last cycle |
| physAddr | output | 32 | Physical address |
| cacheInhibit | output | 1 | Cache-inhibit flag |
| hit | output | 1 | Translation found |
| pageFault | output | 1 | One-cycle page-fault pulse |
| tlbMiss | output | 1 | One-cycle miss pulse |

## Verification
A wrong valid bit or tag shows up on the next lookup of that set. It appears as a spurious `tlbMiss`, or as a hit carrying another way's page number, one cycle after the request. A wrong usage counter changes no translation, so it is visible only through read-back. For that reason the bench reads both ways of the set after each lookup, catching a faulty update within the same cycle. A cache-inhibit flag that loads when it should hold is only exposed by a later miss or probe without `reqThroughCache`. The bench therefore keeps a running expected value across all requests.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Bit positions of the entry words seen on the access port
  localparam int unsigned MATCH_VALID_BIT = 0;
  localparam int unsigned MATCH_USE_LSB   = 2;
  localparam int unsigned XL_CI_BIT       = 0;
  localparam int unsigned XL_URD_BIT      = 1;
  localparam int unsigned XL_UWR_BIT      = 2;
  localparam int unsigned XL_SRD_BIT      = 3;
  localparam int unsigned XL_SWR_BIT      = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic outLoad;
    logic hitFlag;
    logic useUpdate;
    logic ciLoad;
    logic passThru;
    logic zeroAddr;
    logic raiseFault;
    logic raiseMiss;
  } tlbStrobes_t;

endpackage

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqProbe,
  input  logic        reqThroughCache,
  input  logic        xlateOn,
  input  logic        anyHit,
  input  logic        permOk,
  output tlbStrobes_t strb
);

  logic ordinary;
  logic probing;
  logic found;
  logic probeGood;

  assign ordinary  = reqValid && !reqProbe;
  assign probing   = reqValid && reqProbe;
  assign found     = xlateOn && anyHit;
  assign probeGood = !xlateOn || (anyHit && permOk);

  always_comb begin
    strb            = '0;
    strb.outLoad    = reqValid;
    strb.hitFlag    = found;
    strb.passThru   = !xlateOn;
    strb.zeroAddr   = xlateOn && (!anyHit || (reqProbe && !permOk));
    strb.useUpdate  = ordinary && found;
    strb.raiseFault = ordinary && found && !permOk;
    strb.raiseMiss  = ordinary && xlateOn && !anyHit;
    if (ordinary)
      strb.ciLoad = !xlateOn || anyHit;
    else if (probing)
      strb.ciLoad = reqThroughCache && probeGood;
  end

endmodule

// File: rtl/dtlb_datapath.sv
module dtlb_datapath
  import dtlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 13,
  parameter int SET_BITS   = 4,
  parameter int NUM_WAYS   = 2,
  parameter int USE_STATES = 4,
  localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              superMode,
  input  tlbStrobes_t       strb,
  input  logic              entWr,
  input  logic              entSel,
  input  logic [WAY_W-1:0]  entWay,
  input  logic [SET_BITS-1:0] entSet,
  input  logic [ADDR_W-1:0] entWrData,
  output logic [ADDR_W-1:0] entRdData,
  output logic              anyHit,
  output logic              permOk,
  output logic              rspValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic              cacheInhibit,
  output logic              hit,
  output logic              pageFault,
  output logic              tlbMiss
);

  localparam int NUM_SETS = 1 << SET_BITS;
  localparam int TAG_W    = ADDR_W - PAGE_BITS - SET_BITS;
  localparam int PPN_W    = ADDR_W - PAGE_BITS;
  localparam int USE_W    = (USE_STATES > 2) ? 2 : 1;
  localparam logic [USE_W-1:0] USE_TOP = USE_W'(USE_STATES - 1);

  // Entry storage
  logic [NUM_WAYS-1:0] vldMem [NUM_SETS];
  logic [USE_W-1:0]    useMem [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0]    tagMem [NUM_SETS][NUM_WAYS];
  logic [PPN_W-1:0]    ppnMem [NUM_SETS][NUM_WAYS];
  logic [4:0]          attrMem [NUM_SETS][NUM_WAYS];

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    lookupTag;
  logic [NUM_WAYS-1:0] wayHit;
  logic [WAY_W-1:0]    selWay;
  logic [4:0]          selAttr;
  logic [ADDR_W-1:0]   translated;
  logic                entWayOk;

  assign setIdx    = reqAddr[PAGE_BITS +: SET_BITS];
  assign lookupTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign entWayOk  = (int'(entWay) < NUM_WAYS);

  // Per-way compare
  for (genvar w = 0; w < NUM_WAYS; w++) begin : gCmp
    assign wayHit[w] = vldMem[setIdx][w] && (tagMem[setIdx][w] == lookupTag);
  end

  // Highest-numbered matching way wins
  always_comb begin
    selWay = '0;
    anyHit = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wayHit[w]) begin
        selWay = WAY_W'(w);
        anyHit = 1'b1;
      end
    end
  end

  assign selAttr    = attrMem[setIdx][selWay];
  assign translated = {ppnMem[setIdx][selWay], reqAddr[PAGE_BITS-1:0]};

  always_comb begin
    if (superMode)
      permOk = reqWrite ? selAttr[XL_SWR_BIT] : selAttr[XL_SRD_BIT];
    else
      permOk = reqWrite ? selAttr[XL_UWR_BIT] : selAttr[XL_URD_BIT];
  end

  // Valid bits and usage counters: reset, counter update, then entry write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        vldMem[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) useMem[s][w] <= '0;
      end
    end else begin
      if (strb.useUpdate) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == selWay)
            useMem[setIdx][w] <= USE_TOP;
          else if (useMem[setIdx][w] != '0)
            useMem[setIdx][w] <= useMem[setIdx][w] - 1'b1;
        end
      end
      if (entWr && !entSel && entWayOk) begin
        vldMem[entSet][entWay] <= entWrData[MATCH_VALID_BIT];
        useMem[entSet][entWay] <= entWrData[MATCH_USE_LSB +: USE_W];
      end
    end
  end

  // Tag, page number and attributes: written only by software
  always_ff @(posedge clk) begin
    if (entWr && entWayOk) begin
      if (!entSel)
        tagMem[entSet][entWay] <= entWrData[ADDR_W-1 -: TAG_W];
      else begin
        ppnMem[entSet][entWay]  <= entWrData[ADDR_W-1 -: PPN_W];
        attrMem[entSet][entWay] <= entWrData[4:0];
      end
    end
  end

  // Read-back
  always_comb begin
    entRdData = '0;
    if (entWayOk) begin
      if (!entSel) begin
        entRdData[MATCH_VALID_BIT]         = vldMem[entSet][entWay];
        entRdData[MATCH_USE_LSB +: USE_W]  = useMem[entSet][entWay];
        entRdData[ADDR_W-1 -: TAG_W]       = tagMem[entSet][entWay];
      end else begin
        entRdData[ADDR_W-1 -: PPN_W] = ppnMem[entSet][entWay];
        entRdData[4:0]               = attrMem[entSet][entWay];
      end
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      pageFault    <= 1'b0;
      tlbMiss      <= 1'b0;
      hit          <= 1'b0;
      physAddr     <= '0;
      cacheInhibit <= 1'b0;
    end else begin
      rspValid  <= strb.outLoad;
      pageFault <= strb.raiseFault;
      tlbMiss   <= strb.raiseMiss;
      if (strb.outLoad) begin
        hit <= strb.hitFlag;
        if (strb.zeroAddr)      physAddr <= '0;
        else if (strb.passThru) physAddr <= reqAddr;
        else                    physAddr <= translated;
      end
      if (strb.ciLoad)
        cacheInhibit <= strb.passThru ? reqAddr[ADDR_W-1] : selAttr[XL_CI_BIT];
    end
  end

  // Checker state for the counter update
  logic                chkPend;
  logic [SET_BITS-1:0] chkSet;
  logic [WAY_W-1:0]    chkWay;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkPend <= 1'b0;
      chkSet  <= '0;
      chkWay  <= '0;
    end else begin
      chkPend <= strb.useUpdate &&
                 !(entWr && !entSel && entSet == setIdx && entWay == selWay);
      chkSet  <= setIdx;
      chkWay  <= selWay;
    end
  end

  // R6
  hit_way_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkPend |-> useMem[chkSet][chkWay] == USE_TOP);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbMiss |-> (physAddr == '0) && !hit);

  // R1
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad && strb.passThru |=> physAddr == $past(reqAddr));

endmodule

// File: rtl/data_tlb.sv
module data_tlb
  import dtlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 13,
  parameter int SET_BITS   = 4,
  parameter int NUM_WAYS   = 2,
  parameter int USE_STATES = 4,
  parameter bit HAS_MMU    = 1'b1,
  localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqProbe,
  input  logic                reqThroughCache,
  input  logic                superMode,
  input  logic                mmuEnable,
  input  logic                entWr,
  input  logic                entSel,
  input  logic [WAY_W-1:0]    entWay,
  input  logic [SET_BITS-1:0] entSet,
  input  logic [ADDR_W-1:0]   entWrData,
  output logic [ADDR_W-1:0]   entRdData,
  output logic                rspValid,
  output logic [ADDR_W-1:0]   physAddr,
  output logic                cacheInhibit,
  output logic                hit,
  output logic                pageFault,
  output logic                tlbMiss
);

  tlbStrobes_t strb;
  logic        anyHit;
  logic        permOk;
  logic        xlateOn;

  assign xlateOn = HAS_MMU && mmuEnable;

  dtlb_ctrl u_ctrl (
    .reqValid        (reqValid),
    .reqProbe        (reqProbe),
    .reqThroughCache (reqThroughCache),
    .xlateOn         (xlateOn),
    .anyHit          (anyHit),
    .permOk          (permOk),
    .strb            (strb)
  );

  dtlb_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .SET_BITS   (SET_BITS),
    .NUM_WAYS   (NUM_WAYS),
    .USE_STATES (USE_STATES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .superMode    (superMode),
    .strb         (strb),
    .entWr        (entWr),
    .entSel       (entSel),
    .entWay       (entWay),
    .entSet       (entSet),
    .entWrData    (entWrData),
    .entRdData    (entRdData),
    .anyHit       (anyHit),
    .permOk       (permOk),
    .rspValid     (rspValid),
    .physAddr     (physAddr),
    .cacheInhibit (cacheInhibit),
    .hit          (hit),
    .pageFault    (pageFault),
    .tlbMiss      (tlbMiss)
  );

  // R8
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqProbe |=> !pageFault && !tlbMiss);

  // R4
  one_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pageFault, tlbMiss}));

  // R7
  miss_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbMiss |-> $past(reqValid) && rspValid);

endmodule

// File: tb/sim_data_tlb.sv
module sim_data_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqProbe = 0, reqThroughCache = 0;
  logic        superMode = 0, mmuEnable = 0;
  logic [31:0] reqAddr = '0;
  logic        entWr = 0, entSel = 0;
  logic        entWay = 0;
  logic [3:0]  entSet = '0;
  logic [31:0] entWrData = '0;
  logic [31:0] entRdData, physAddr;
  logic        rspValid, cacheInhibit, hit, pageFault, tlbMiss;

  always #10 clk = ~clk;

  data_tlb u0 (.*);

  int passCnt = 0, totalCnt = 0;

  // Bench model
  logic        mVld [16][2];
  logic [1:0]  mUse [16][2];
  logic [14:0] mTag [16][2];
  logic [18:0] mPpn [16][2];
  logic [4:0]  mAttr[16][2];
  logic        mCi;
  logic [14:0] tagPool [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  function automatic logic [31:0] matchWord(int s, int w);
    return {mTag[s][w], 13'd0, mUse[s][w], 1'b0, mVld[s][w]};
  endfunction

  function automatic logic [31:0] xlWord(int s, int w);
    return {mPpn[s][w], 8'd0, mAttr[s][w]};
  endfunction

  function automatic logic permOf(logic [4:0] a, logic wr, logic sup);
    if (sup) return wr ? a[4] : a[3];
    return wr ? a[2] : a[1];
  endfunction

  task automatic modelWrite(logic sel, int w, int s, logic [31:0] d);
    if (!sel) begin
      mVld[s][w] = d[0]; mUse[s][w] = d[3:2]; mTag[s][w] = d[31:17];
    end else begin
      mPpn[s][w] = d[31:13]; mAttr[s][w] = d[4:0];
    end
  endtask

  task automatic doWrite(logic sel, int w, int s, logic [31:0] d);
    @(negedge clk);
    entWr = 1; entSel = sel; entWay = w[0]; entSet = s[3:0]; entWrData = d;
    @(negedge clk);
    entWr = 0;
    modelWrite(sel, w, s, d);
  endtask

  // Expected outcome of one lookup; updates the model state
  task automatic predict(logic [31:0] a, logic wr, logic sup, logic en,
                         logic pr, logic th,
                         output logic [31:0] ePa, output logic eHit,
                         output logic eFlt, output logic eMiss);
    int s, way;
    logic ok;
    s = int'(a[16:13]);
    ePa = '0; eHit = 0; eFlt = 0; eMiss = 0;
    if (!en) begin
      ePa = a;
      if (!pr || th) mCi = a[31];
      return;
    end
    way = -1;
    for (int w = 0; w < 2; w++)
      if (mVld[s][w] && mTag[s][w] == a[31:17]) way = w;
    if (way < 0) begin
      eMiss = !pr;
      return;
    end
    eHit = 1;
    ok = permOf(mAttr[s][way], wr, sup);
    if (pr) begin
      if (ok) begin
        ePa = {mPpn[s][way], a[12:0]};
        if (th) mCi = mAttr[s][way][0];
      end
    end else begin
      eFlt = !ok;
      ePa = {mPpn[s][way], a[12:0]};
      mCi = mAttr[s][way][0];
      for (int w = 0; w < 2; w++)
        if (w == way) mUse[s][w] = 2'd3;
        else if (mUse[s][w] != 0) mUse[s][w] = mUse[s][w] - 2'd1;
    end
  endtask

  task automatic checkSet(int s, string req);
    entSel = 0; entSet = s[3:0];
    for (int w = 0; w < 2; w++) begin
      entWay = w[0];
      #1;
      chk(req, entRdData, matchWord(s, w));
    end
  endtask

  task automatic doLookup(logic [31:0] a, logic wr, logic sup, logic en,
                          logic pr, logic th, string req);
    logic [31:0] ePa; logic eHit, eFlt, eMiss;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = wr; superMode = sup;
    mmuEnable = en; reqProbe = pr; reqThroughCache = th;
    predict(a, wr, sup, en, pr, th, ePa, eHit, eFlt, eMiss);
    @(negedge clk);
    reqValid = 0;
    chk({req, " addr"}, physAddr, ePa);
    chk({req, " hit"}, {31'd0, hit}, {31'd0, eHit});
    chk({req, " fault"}, {31'd0, pageFault}, {31'd0, eFlt});
    chk({req, " miss"}, {31'd0, tlbMiss}, {31'd0, eMiss});
    chk({req, " ci"}, {31'd0, cacheInhibit}, {31'd0, mCi});
    checkSet(int'(a[16:13]), "R6 usage counters");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [31:0] ePa; logic eHit, eFlt, eMiss;
    void'($urandom(32'h1d7b));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 2; w++) begin
        mVld[s][w] = 0; mUse[s][w] = 0; mTag[s][w] = 'x;
        mPpn[s][w] = 'x; mAttr[s][w] = 'x;
      end
    mCi = 0;
    for (int i = 0; i < 4; i++) tagPool[i] = 15'($urandom);

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9 reset state
    chk("R9 rspValid", {31'd0, rspValid}, 32'd0);
    chk("R9 physAddr", physAddr, 32'd0);
    chk("R9 ci", {31'd0, cacheInhibit}, 32'd0);
    chk("R9 flags", {29'd0, hit, pageFault, tlbMiss}, 32'd0);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 2; w++) begin
        entSel = 0; entSet = s[3:0]; entWay = w[0]; #1;
        chk("R9 entry valid/usage", entRdData & 32'hF, 32'd0);
      end

    // R1 pass-through boundary
    doLookup(32'h7FFF_FFFF, 0, 0, 0, 0, 0, "R1 below");
    doLookup(32'h8000_0000, 1, 1, 0, 0, 0, "R1 at");
    doLookup(32'h1234_5678, 0, 0, 0, 1, 0, "R1 probe no-thru");
    doLookup(32'h0000_0010, 0, 0, 0, 1, 1, "R1 probe thru");

    // R7 miss on empty buffer
    doLookup(32'hC000_4000, 0, 1, 1, 0, 0, "R7 empty miss");

    // R11 entry formats, R3 duplicate tags in set 5
    doWrite(1, 0, 5, {19'h1_1111, 8'd0, 5'b11110});
    doWrite(1, 1, 5, {19'h2_2222, 8'd0, 5'b11111});
    doWrite(0, 0, 5, {tagPool[0], 13'd0, 2'd2, 1'b0, 1'b1});
    doWrite(0, 1, 5, {tagPool[0], 13'd0, 2'd0, 1'b0, 1'b1});
    entSel = 1; entSet = 4'd5; entWay = 1'b1; #1;
    chk("R11 translate read-back", entRdData, xlWord(5, 1));
    doLookup({tagPool[0], 4'd5, 13'h0ABC}, 0, 0, 1, 0, 0, "R3 highest way");

    // R4 permission cases on set 5 way 1: make it user-read only
    doWrite(1, 1, 5, {19'h2_2222, 8'd0, 5'b00010});
    doLookup({tagPool[0], 4'd5, 13'h0001}, 1, 0, 1, 0, 0, "R4 user write");
    doLookup({tagPool[0], 4'd5, 13'h0002}, 0, 1, 1, 0, 0, "R4 super read");
    doLookup({tagPool[0], 4'd5, 13'h0003}, 0, 0, 1, 0, 0, "R4 user read ok");
    doLookup({tagPool[0], 4'd5, 13'h0004}, 1, 1, 1, 1, 1, "R8 probe fail");

    // R2 tag mismatch in same set
    doLookup({tagPool[1] ^ 15'h1, 4'd5, 13'h0005}, 0, 0, 1, 0, 0, "R2 tag mismatch");

    // R10 same-cycle write and lookup on set 5 way 1
    @(negedge clk);
    reqValid = 1; reqAddr = {tagPool[0], 4'd5, 13'h0100}; reqWrite = 0;
    superMode = 0; mmuEnable = 1; reqProbe = 0; reqThroughCache = 0;
    entWr = 1; entSel = 0; entWay = 1'b1; entSet = 4'd5;
    entWrData = {tagPool[0], 13'd0, 2'd1, 1'b0, 1'b0};
    predict(reqAddr, 0, 0, 1, 0, 0, ePa, eHit, eFlt, eMiss);
    modelWrite(0, 1, 5, entWrData);
    @(negedge clk);
    reqValid = 0; entWr = 0;
    chk("R10 old translation", physAddr, ePa);
    chk("R10 old hit", {31'd0, hit}, {31'd0, eHit});
    checkSet(5, "R10 write lands after");

    // R5 R6 R8 random mix
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 2; w++) begin
        doWrite(1, w, s, {19'($urandom), 8'd0, 5'($urandom)});
        doWrite(0, w, s, {tagPool[$urandom % 4], 13'd0, 2'($urandom), 1'b0,
                          1'(($urandom % 8) != 0)});
      end
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = {tagPool[$urandom % 4], 4'($urandom), 13'($urandom)};
      if (i % 25 == 24)
        doWrite(0, $urandom % 2, $urandom % 16,
                {tagPool[$urandom % 4], 13'd0, 2'($urandom), 1'b0, 1'($urandom)});
      doLookup(a, 1'($urandom), 1'($urandom), 1'(($urandom % 10) != 0),
               1'(($urandom % 4) == 0), 1'($urandom), "R5 random lookup");
    end

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule